// File: doc/BRIEF.md
# Four-Way Translation Buffer with Access Protection

This block is a software-refilled translation lookaside buffer. It has four ways, and each way holds sixteen entries. One instance serves either the instruction side or the data side; a parameter chooses which. Each entry holds the following:

- a virtual page number and an 8-bit address-space tag;
- a physical frame number;
- five attribute flags: global, valid, kernel-only, writable and executable.

Software loads an entry through a write port that names the way and the index directly.

A lookup takes a 32-bit virtual address with 8 KB pages, an access kind, a user/kernel flag and a debug flag. It compares the page number and the current tag against the four entries at the selected index. It then applies the protection checks that a 4-bit enable input turns on. One cycle later it returns one of two results:

- on success, the physical address and the granted permissions;
- on failure, the exception vector for the fault.

Every fault that is not a debug lookup updates two registers that software reads to refill the buffer. The cause word records the page, access kind and tag. The select word records the way and index to write. A 16-bit LFSR picks the way to replace after a miss.

Top module: `tlb_prot_xlate`

## Requirements
- R1: After reset `res_valid` is 0, `cause_q` is 0, `sel_q` is 0, every stored entry is cleared to zero, and the LFSR holds 0xCCCC.
- R2: A write with `wr_en` stores the page, tag, frame and attributes at (`wr_way`, `wr_idx`). `wr_attr` is ordered bit 4 global, bit 3 valid, bit 2 kernel, bit 1 writable, bit 0 executable. The write is visible to any lookup issued in a later cycle. The index of a lookup is address bits 16:13, and the page number is bits 31:13.
- R3: An entry hits when its page number equals address bits 31:13 and either its global flag is set or its tag equals `cur_pid`. When several ways hit, the lowest-numbered way is used.
- R4: Each lookup gives `res_valid` for exactly one cycle, in the cycle after `lk_valid`. On success `res_fault` is 0 and `res_paddr` is the frame number in bits 31:13 with address bits 12:0 passed through.
- R5: A lookup with no hit faults with vector base+0. The select register's way field then takes LFSR bits 1:0 as they were before the LFSR advances.
- R6: With `chk_en[2]` set, a user-mode access to a kernel-only page faults with base+2. This check has the highest priority of all the checks.
- R7: A write (`lk_acc`=1) to a non-writable page with `chk_en[3]` set faults with base+3. An execute (`lk_acc`=2) of a non-executable page with `chk_en[1]` set also faults with base+3. Both checks rank below the kernel check.
- R8: With `chk_en[0]` set, a hit on a page whose valid flag is clear faults with base+1. This check has the lowest priority.
- R9: The vector base is 4 when `IS_INSN`=1 and 8 when `IS_INSN`=0. `res_vec` carries base plus the fault offset.
- R10: On success `res_perm` is {exec, write, read}. Read is always 1 and write equals the entry's writable flag. Exec is 1 only when `IS_INSN`=1 and either `chk_en[1]` is clear or the entry is executable. On a fault `res_perm` is 0.
- R11: Every non-debug fault steps the LFSR once. A step shifts the LFSR right by one bit and places in bit 15 the parity of the state ANDed with 0x8805.
- R12: A non-debug fault loads `sel_q` with the index in bits 3:0 and the way in bits 5:4; after a protection fault the way is the hitting way. It also loads `cause_q` with `cur_pid` in bits 7:0, the access code in bits 9:8 (0 read, 1 write, 2 execute), zero in bits 12:10 and the page number in bits 31:13.
- R13: A lookup with `lk_debug` set returns its result normally. It leaves `cause_q`, `sel_q` and the LFSR unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load one entry |
| wr_way | input | 2 | Way to load |
| wr_idx | input | 4 | Index to load |
| wr_vpn | input | 19 | Virtual page number to store |
| wr_pid | input | 8 | Address-space tag to store |
| wr_pfn | input | 19 | Physical frame number to store |
| wr_attr | input | 5 | {global, valid, kernel, writable, executable} |
| cur_pid | input | 8 | Current address-space tag |
| chk_en | input | 4 | Check enables {W, K, X, V} |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_acc | input | 2 | Access code: 0 read, 1 write, 2 execute |
| lk_user | input | 1 | Access is made in user mode |
| lk_debug | input | 1 | Side-effect-free lookup |
| res_valid | output | 1 | Result is present |
| res_fault | output | 1 | Lookup failed |
| res_vec | output | 4 | Exception vector on a fault |
| res_paddr | output | 32 | Physical address on success |
| res_perm | output | 3 | {exec, write, read} permissions on success |
| cause_q | output | 32 | Fault cause word |
| sel_q | output | 6 | Refill select word {way, index} |

## Verification
The bench builds two copies that share all stimulus. One copy uses `IS_INSN`=0, which gives vector base 8 and never grants exec. The other uses `IS_INSN`=1, which gives vector base 4 and grants exec. Running the same lookup on both checks each variant's vector numbering and exec rule in the same cycle. All other parameters keep their defaults: four ways, sixteen indices and the 0xCCCC seed with 0x8805 taps. With these values, a short run of misses walks the LFSR through all four victim ways, and the results can be checked against a bench-side step of the LFSR.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
  localparam int PAGE_BITS = 13;
  localparam int VPN_W     = 32 - PAGE_BITS;
  localparam int PID_W     = 8;
  localparam int ATTR_W    = 5;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic [VPN_W-1:0] pfn;
    logic             glob;
    logic             vld;
    logic             kern;
    logic             wrt;
    logic             exe;
  } entry_t;

  // Parity feedback shift: new bit enters at the top
  function automatic logic [15:0] lfsr_next(input logic [15:0] s, input logic [15:0] taps);
    return {^(s & taps), s[15:1]};
  endfunction

  function automatic logic [31:0] cause_word(input logic [VPN_W-1:0] vpn,
                                             input logic [1:0] acc,
                                             input logic [PID_W-1:0] pid);
    return {vpn, 3'b000, acc, pid};
  endfunction

  function automatic logic [31:0] phys_addr(input logic [VPN_W-1:0] pfn,
                                            input logic [PAGE_BITS-1:0] ofs);
    return {pfn, ofs};
  endfunction
endpackage

// File: rtl/tlb_way_array.sv
module tlb_way_array
  import tlbp_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  entry_t           wr_ent_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output entry_t           rd_ent_o
);
  localparam int DEPTH = 1 << IDX_W;

  entry_t mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wr_idx_i] <= wr_ent_i;
    end
  end

  assign rd_ent_o = mem_q[rd_idx_i];
endmodule

// File: rtl/tlb_victim_lfsr.sv
module tlb_victim_lfsr
  import tlbp_pkg::*;
#(
  parameter logic [15:0] SEED = 16'hCCCC,
  parameter logic [15:0] TAPS = 16'h8805
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_i,
  output logic [15:0] state_o
);
  logic [15:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= SEED;
    else if (step_i) state_q <= lfsr_next(state_q, TAPS);
  end

  assign state_o = state_q;

  // R11
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(state_q));
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlbp_pkg::*;
#(
  parameter int WAYS    = 4,
  parameter bit IS_INSN = 1'b0,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  entry_t           ent_i [WAYS],
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic [1:0]       acc_i,
  input  logic             user_i,
  input  logic [3:0]       chk_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] way_o,
  output logic             fault_o,
  output logic [1:0]       off_o,
  output logic [2:0]       perm_o,
  output logic [VPN_W-1:0] pfn_o
);
  logic [WAYS-1:0] match;
  entry_t          sel_ent;
  logic            k_viol, w_viol, x_viol, v_viol;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = (ent_i[w].vpn == vpn_i) &&
                      (ent_i[w].glob || (ent_i[w].pid == pid_i));
  end

  // Scan from the top so the lowest matching way is kept last
  always_comb begin
    hit_o   = 1'b0;
    way_o   = '0;
    sel_ent = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit_o   = 1'b1;
        way_o   = WAY_W'(w);
        sel_ent = ent_i[w];
      end
    end
  end

  assign k_viol = chk_i[2] && sel_ent.kern && user_i;
  assign w_viol = (acc_i == ACC_WRITE) && chk_i[3] && !sel_ent.wrt;
  assign x_viol = (acc_i == ACC_EXEC)  && chk_i[1] && !sel_ent.exe;
  assign v_viol = chk_i[0] && !sel_ent.vld;

  always_comb begin
    if (!hit_o)                off_o = 2'd0;
    else if (k_viol)           off_o = 2'd2;
    else if (w_viol || x_viol) off_o = 2'd3;
    else if (v_viol)           off_o = 2'd1;
    else                       off_o = 2'd0;
  end

  assign fault_o = !hit_o || k_viol || w_viol || x_viol || v_viol;
  assign pfn_o   = sel_ent.pfn;

  always_comb begin
    perm_o = 3'b000;
    if (!fault_o) begin
      perm_o[0] = 1'b1;
      perm_o[1] = sel_ent.wrt;
      perm_o[2] = IS_INSN && (!chk_i[1] || sel_ent.exe);
    end
  end
endmodule

// File: rtl/tlb_prot_xlate.sv
module tlb_prot_xlate
  import tlbp_pkg::*;
#(
  parameter int          WAYS      = 4,
  parameter int          IDX_W     = 4,
  parameter bit          IS_INSN   = 1'b0,
  parameter logic [15:0] LFSR_SEED = 16'hCCCC,
  parameter logic [15:0] LFSR_TAPS = 16'h8805,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SEL_W  = WAY_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [VPN_W-1:0] wr_pfn,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic [PID_W-1:0] cur_pid,
  input  logic [3:0]       chk_en,
  input  logic             lk_valid,
  input  logic [31:0]      lk_vaddr,
  input  logic [1:0]       lk_acc,
  input  logic             lk_user,
  input  logic             lk_debug,
  output logic             res_valid,
  output logic             res_fault,
  output logic [3:0]       res_vec,
  output logic [31:0]      res_paddr,
  output logic [2:0]       res_perm,
  output logic [31:0]      cause_q,
  output logic [SEL_W-1:0] sel_q
);
  localparam logic [3:0] VEC_BASE = IS_INSN ? 4'd4 : 4'd8;

  entry_t           wr_ent;
  entry_t           rd_ent [WAYS];
  logic [VPN_W-1:0] lk_vpn;
  logic [IDX_W-1:0] lk_idx;
  logic [15:0]      lfsr;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic             fault;
  logic [1:0]       off;
  logic [2:0]       perm;
  logic [VPN_W-1:0] pfn;
  // Named events used by the assertions
  logic             fault_evt;
  logic [WAY_W-1:0] victim_way;

  assign lk_vpn = lk_vaddr[31:PAGE_BITS];
  assign lk_idx = lk_vaddr[PAGE_BITS+IDX_W-1:PAGE_BITS];

  assign wr_ent = '{vpn: wr_vpn, pid: wr_pid, pfn: wr_pfn,
                    glob: wr_attr[4], vld: wr_attr[3], kern: wr_attr[2],
                    wrt: wr_attr[1], exe: wr_attr[0]};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_way_array #(.IDX_W(IDX_W)) way_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (wr_en && (wr_way == WAY_W'(w))),
      .wr_idx_i (wr_idx),
      .wr_ent_i (wr_ent),
      .rd_idx_i (lk_idx),
      .rd_ent_o (rd_ent[w])
    );
  end

  tlb_perm_check #(.WAYS(WAYS), .IS_INSN(IS_INSN)) chk_i (
    .ent_i   (rd_ent),
    .vpn_i   (lk_vpn),
    .pid_i   (cur_pid),
    .acc_i   (lk_acc),
    .user_i  (lk_user),
    .chk_i   (chk_en),
    .hit_o   (hit),
    .way_o   (hit_way),
    .fault_o (fault),
    .off_o   (off),
    .perm_o  (perm),
    .pfn_o   (pfn)
  );

  assign fault_evt  = lk_valid && !lk_debug && fault;
  assign victim_way = hit ? hit_way : lfsr[WAY_W-1:0];

  tlb_victim_lfsr #(.SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) rng_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (fault_evt),
    .state_o (lfsr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_fault <= 1'b0;
      res_vec   <= '0;
      res_paddr <= '0;
      res_perm  <= '0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_fault <= fault;
        res_vec   <= VEC_BASE + {2'b00, off};
        res_paddr <= fault ? 32'h0 : phys_addr(pfn, lk_vaddr[PAGE_BITS-1:0]);
        res_perm  <= perm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      sel_q   <= '0;
    end else if (fault_evt) begin
      cause_q <= cause_word(lk_vpn, lk_acc, cur_pid);
      sel_q   <= {victim_way, lk_idx};
    end
  end

  // R9
  vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_vec[3:2] == VEC_BASE[3:2]));

  // R10
  read_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault) |-> res_perm[0]);

  // R10
  fault_no_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_perm == 3'b000));

  // R10
  data_no_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !IS_INSN) |-> !res_perm[2]);

  // R13
  dbg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_debug) |=> ($stable(cause_q) && $stable(sel_q)));

  // R12
  cause_pid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (cause_q[7:0] == $past(cur_pid)));

  // R4
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
endmodule

// File: tb/tlb_prot_xlate_tb_top.sv
`timescale 1ns/1ps
module tlb_prot_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_way = '0;
  logic [3:0]  wr_idx = '0;
  logic [18:0] wr_vpn = '0, wr_pfn = '0;
  logic [7:0]  wr_pid = '0, cur_pid = '0;
  logic [4:0]  wr_attr = '0;
  logic [3:0]  chk_en = '0;
  logic        lk_valid = 1'b0, lk_user = 1'b0, lk_debug = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_acc = '0;

  logic        rv_d, rf_d, rv_x, rf_x;
  logic [3:0]  vec_d, vec_x;
  logic [31:0] pa_d, pa_x, cause_d, cause_x;
  logic [2:0]  perm_d, perm_x;
  logic [5:0]  sel_d, sel_x;

  always #4 clk = ~clk;

  tlb_prot_xlate #(.IS_INSN(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_pid(wr_pid), .wr_pfn(wr_pfn), .wr_attr(wr_attr),
    .cur_pid(cur_pid), .chk_en(chk_en), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_acc(lk_acc), .lk_user(lk_user), .lk_debug(lk_debug),
    .res_valid(rv_d), .res_fault(rf_d), .res_vec(vec_d), .res_paddr(pa_d),
    .res_perm(perm_d), .cause_q(cause_d), .sel_q(sel_d));

  tlb_prot_xlate #(.IS_INSN(1'b1)) dut_x (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_pid(wr_pid), .wr_pfn(wr_pfn), .wr_attr(wr_attr),
    .cur_pid(cur_pid), .chk_en(chk_en), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_acc(lk_acc), .lk_user(lk_user), .lk_debug(lk_debug),
    .res_valid(rv_x), .res_fault(rf_x), .res_vec(vec_x), .res_paddr(pa_x),
    .res_perm(perm_x), .cause_q(cause_x), .sel_q(sel_x));

  typedef struct {
    logic        fault;
    logic [1:0]  off;
    logic [31:0] paddr;
    logic [2:0]  pd, px;
    logic [31:0] cause;
    logic [5:0]  sel;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  bit   finished = 1'b0;

  // Reference model state, kept from the requirements
  logic [18:0] m_vpn [4][16];
  logic [7:0]  m_pid [4][16];
  logic [18:0] m_pfn [4][16];
  logic [4:0]  m_att [4][16];
  logic [15:0] m_rng;
  logic [31:0] m_cause;
  logic [5:0]  m_sel;

  function automatic logic [15:0] rng_step(input logic [15:0] s);
    int ones = 0;
    for (int b = 0; b < 16; b++)
      if (s[b] && (16'h8805 >> b) & 16'h1) ones++;
    return {ones[0], s[15:1]};
  endfunction

  task automatic ck(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put(input int w, input int ix, input logic [18:0] vpn, input logic [7:0] pid,
                     input logic [18:0] pfn, input logic [4:0] att);
    @(negedge clk);
    wr_en = 1'b1; wr_way = w[1:0]; wr_idx = ix[3:0];
    wr_vpn = vpn; wr_pid = pid; wr_pfn = pfn; wr_attr = att;
    m_vpn[w][ix] = vpn; m_pid[w][ix] = pid; m_pfn[w][ix] = pfn; m_att[w][ix] = att;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: builds the expected item, then issues the lookup
  task automatic look(input logic [31:0] va, input logic [1:0] acc, input bit usr,
                      input bit dbg, input string req);
    exp_t e;
    int   ix = int'(va[16:13]);
    int   hw = -1;
    logic [4:0] a;
    bit kv, wv, xv, vv;
    @(negedge clk);
    for (int w = 0; w < 4 && hw < 0; w++)
      if (m_vpn[w][ix] == va[31:13] && (m_att[w][ix][4] || m_pid[w][ix] == cur_pid)) hw = w;
    e.req = req; e.off = 2'd0; e.paddr = 32'h0; e.pd = 3'b000; e.px = 3'b000;
    if (hw < 0) begin
      e.fault = 1'b1;
    end else begin
      a  = m_att[hw][ix];
      kv = chk_en[2] && a[2] && usr;
      wv = (acc == 2'd1) && chk_en[3] && !a[1];
      xv = (acc == 2'd2) && chk_en[1] && !a[0];
      vv = chk_en[0] && !a[3];
      e.fault = kv || wv || xv || vv;
      if (kv) e.off = 2'd2;
      else if (wv || xv) e.off = 2'd3;
      else if (vv) e.off = 2'd1;
      if (!e.fault) begin
        e.paddr = {m_pfn[hw][ix], va[12:0]};
        e.pd = {1'b0, a[1], 1'b1};
        e.px = {(!chk_en[1] || a[0]), a[1], 1'b1};
      end
    end
    if (e.fault && !dbg) begin
      m_sel   = {(hw < 0) ? m_rng[1:0] : hw[1:0], va[16:13]};
      m_cause = {va[31:13], 3'b000, acc, cur_pid};
      m_rng   = rng_step(m_rng);
    end
    e.cause = m_cause; e.sel = m_sel;
    q.push_back(e);
    lk_valid = 1'b1; lk_vaddr = va; lk_acc = acc; lk_user = usr; lk_debug = dbg;
    @(negedge clk);
    lk_valid = 1'b0; lk_debug = 1'b0;
  endtask

  // Monitor: pops one item for each result
  always @(negedge clk) begin
    if (rst_n && (rv_d || rv_x)) begin
      exp_t e;
      ck("R4", "valid pair", {31'd0, rv_x}, {31'd0, rv_d});
      if (q.size() == 0) begin
        ck("R4", "unexpected result", 32'd1, 32'd0);
      end else begin
        e = q.pop_front();
        ck(e.req, "fault d", {31'd0, rf_d}, {31'd0, e.fault});
        ck(e.req, "fault x", {31'd0, rf_x}, {31'd0, e.fault});
        if (e.fault) begin
          // R9: base 8 data, base 4 instruction
          ck(e.req, "vec d R9", {28'd0, vec_d}, 32'd8 + e.off);
          ck(e.req, "vec x R9", {28'd0, vec_x}, 32'd4 + e.off);
        end else begin
          ck(e.req, "paddr", pa_d, e.paddr);
          ck(e.req, "paddr x", pa_x, e.paddr);
        end
        ck(e.req, "perm d R10", {29'd0, perm_d}, {29'd0, e.pd});
        ck(e.req, "perm x R10", {29'd0, perm_x}, {29'd0, e.px});
        ck(e.req, "cause R12", cause_d, e.cause);
        ck(e.req, "cause x R12", cause_x, e.cause);
        ck(e.req, "sel R12", {26'd0, sel_d}, {26'd0, e.sel});
        ck(e.req, "sel x R12", {26'd0, sel_x}, {26'd0, e.sel});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 16; i++) begin
        m_vpn[w][i] = '0; m_pid[w][i] = '0; m_pfn[w][i] = '0; m_att[w][i] = '0;
      end
    m_rng = 16'hCCCC; m_cause = '0; m_sel = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    ck("R1", "res_valid", {31'd0, rv_d}, 32'd0);
    ck("R1", "cause", cause_d, 32'd0);
    ck("R1", "sel", {26'd0, sel_d}, 32'd0);
    rst_n = 1'b1;
    cur_pid = 8'h11;
    chk_en = 4'b0000;
    repeat (2) @(negedge clk);
    ck("R1", "res_valid idle", {31'd0, rv_d}, 32'd0);

    // R5 miss on empty buffer; R11 victim ways follow the LFSR
    look(32'h4000_6000, 2'd0, 1'b0, 1'b0, "R5");
    look(32'h1234_4abc, 2'd1, 1'b0, 1'b0, "R11");
    look(32'h8888_2000, 2'd2, 1'b0, 1'b0, "R11");
    look(32'h0000_e010, 2'd0, 1'b0, 1'b0, "R11");
    // R1 cleared entry: page 0 with tag 0 hits a zeroed slot
    cur_pid = 8'h00;
    look(32'h0000_0123, 2'd0, 1'b0, 1'b0, "R1");
    cur_pid = 8'h11;

    // R2 load and hit; index from bits 16:13
    put(1, 3, 19'h0a003, 8'h11, 19'h55555, 5'b01011);
    look({19'h0a003, 13'h1abc}, 2'd0, 1'b0, 1'b0, "R2");
    look({19'h0a003, 13'h0004}, 2'd1, 1'b0, 1'b0, "R4");

    // R3 lowest way wins; tag mismatch misses; global ignores tag
    put(2, 5, 19'h07775, 8'h11, 19'h22222, 5'b01010);
    put(0, 5, 19'h07775, 8'h11, 19'h11111, 5'b01011);
    look({19'h07775, 13'h0777}, 2'd0, 1'b0, 1'b0, "R3");
    put(3, 9, 19'h03339, 8'h42, 19'h33333, 5'b01011);
    look({19'h03339, 13'h0000}, 2'd0, 1'b0, 1'b0, "R3");
    put(3, 9, 19'h03339, 8'h42, 19'h33333, 5'b11011);
    look({19'h03339, 13'h0010}, 2'd0, 1'b0, 1'b0, "R3");

    // R6 kernel page, user mode, all checks on
    put(1, 6, 19'h01236, 8'h11, 19'h44444, 5'b00100);
    chk_en = 4'b1111;
    look({19'h01236, 13'h0}, 2'd1, 1'b1, 1'b0, "R6");
    look({19'h01236, 13'h0}, 2'd0, 1'b0, 1'b0, "R8");
    chk_en = 4'b1011;
    look({19'h01236, 13'h0}, 2'd1, 1'b1, 1'b0, "R7");
    chk_en = 4'b0100;
    look({19'h01236, 13'h0}, 2'd0, 1'b0, 1'b0, "R6");

    // R7 write and exec protection; R10 exec grant
    chk_en = 4'b1010;
    look({19'h0a003, 13'h0}, 2'd1, 1'b0, 1'b0, "R7");
    look({19'h07775, 13'h0}, 2'd1, 1'b0, 1'b0, "R7");
    look({19'h0a003, 13'h0}, 2'd2, 1'b0, 1'b0, "R7");
    look({19'h03339, 13'h0}, 2'd2, 1'b0, 1'b0, "R10");
    chk_en = 4'b0000;
    look({19'h0a003, 13'h0}, 2'd2, 1'b0, 1'b0, "R10");

    // R8 invalid page, lowest priority
    put(2, 12, 19'h0444c, 8'h11, 19'h66666, 5'b00000);
    chk_en = 4'b0001;
    look({19'h0444c, 13'h0}, 2'd0, 1'b0, 1'b0, "R8");
    chk_en = 4'b1001;
    look({19'h0444c, 13'h0}, 2'd1, 1'b0, 1'b0, "R8");

    // R13 debug lookups leave refill state alone
    look(32'h7654_2000, 2'd0, 1'b0, 1'b1, "R13");
    look({19'h0444c, 13'h0}, 2'd1, 1'b0, 1'b1, "R13");
    look(32'h7654_2000, 2'd0, 1'b0, 1'b0, "R13");

    // R11 further misses walk the LFSR
    chk_en = 4'b0000;
    for (int k = 0; k < 10; k++)
      look(32'h9000_0000 + (k << 13), 2'(k % 3), 1'b0, 1'b0, "R11");

    repeat (4) @(negedge clk);
    ck("R4", "queue drained", q.size(), 32'd0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule